// File: doc/BRIEF.md
# Register-Indirect Branch Resolver with Direction Predictor

This unit settles control transfers in a pipelined core whose jump targets come from a register and not from a PC-relative offset. The execute side presents one control-transfer operation per cycle: its opcode, the address it was fetched from, the direction the front end predicted for it, the register value that holds the target, and the current condition flags. In the same cycle the unit returns the resolved direction, the correct next PC and a mask of flags to clear. A conditional jump that is taken consumes the flag it tested. One cycle later, if the front end followed the wrong path, the unit raises a flush request together with the PC to restart from.

A table of 2-bit saturating counters, indexed by the low bits of the PC, gives the fetch stage a predicted direction for the instruction it is fetching. Only conditional jumps train the table. Unconditional transfers (plain jump, call, return, return-from-interrupt) are always taken. Their target is only known at resolve time, so they always request a redirect.

Top module: `br_resolver`

## Requirements
- R1: After reset, every counter is weakly-not-taken (value 1). `fetch_pred_taken` is 0 for every table index, and `flush` is 0.
- R2: Opcode encoding on `rs_op`: 0 = no transfer, 1 = jump-if-zero, 2 = jump-if-negative, 3 = jump-if-carry, 4 = jump, 5 = call, 6 = return, 7 = return-from-interrupt. Flag bits on `rs_flags`: bit0 = Z, bit1 = N, bit2 = C. Opcodes 1, 2 and 3 are taken exactly when Z, N or C respectively is 1.
- R3: When a conditional jump is taken, `flag_clr` has exactly the bit of the flag it tested set. In every other case `flag_clr` is 0.
- R4: `rs_next_pc` equals `rs_target` when `rs_taken` is 1, and equals `rs_pc + 1` otherwise.
- R5: Opcodes 4 to 7 are always taken with target `rs_target`. They always raise `flush` in the next cycle, whatever `rs_pred` says.
- R6: A valid conditional jump increments the counter at index `rs_pc[IDX_W-1:0]` when taken and decrements it when not taken. The counter saturates at 0 and 3. `fetch_pred_taken` is 1 exactly when the counter at `fetch_pc[IDX_W-1:0]` is 2 or 3, and it reflects an update from the following cycle on.
- R7: Opcodes 0 and 4 to 7 leave every counter unchanged.
- R8: In the cycle after a valid conditional jump whose resolved direction differs from `rs_pred`, `flush` is 1 for exactly one cycle and `flush_pc` holds that jump's next PC. A matching prediction raises no flush.
- R9: While `rs_valid` is 0, or when `rs_op` is 0: `rs_taken` is 0, `flag_clr` is 0, no flush follows, and the counters are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | Address being fetched |
| fetch_pred_taken | output | 1 | Predicted direction for `fetch_pc` |
| rs_valid | input | 1 | A transfer is being resolved this cycle |
| rs_op | input | 3 | Transfer opcode (encoding in R2) |
| rs_pc | input | PC_W | Address of the transfer being resolved |
| rs_pred | input | 1 | Direction predicted at fetch for this transfer |
| rs_target | input | PC_W | Register value holding the target |
| rs_flags | input | 3 | Current flags: {C, N, Z} |
| rs_taken | output | 1 | Resolved direction |
| rs_next_pc | output | PC_W | Correct next PC |
| flag_clr | output | 3 | Flags to clear, same bit layout as `rs_flags` |
| flush | output | 1 | One-cycle redirect request |
| flush_pc | output | PC_W | Restart address while `flush` is 1 |

## Verification
The bench builds the unit with its defaults: 32-bit PCs and a 4-bit index, which gives 16 counters. The small table allows every index to be driven from weakly-not-taken up into both saturation limits and back. The bench also covers the full cross of all eight opcodes, all eight flag combinations and both predictions, and it spreads those vectors across every table index. A bench-side counter model then checks the trained prediction for each index after every vector.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_JZ   = 3'd1,
        OP_JN   = 3'd2,
        OP_JC   = 3'd3,
        OP_JMP  = 3'd4,
        OP_CALL = 3'd5,
        OP_RET  = 3'd6,
        OP_RTI  = 3'd7
    } xfer_op_e;

    typedef struct packed {
        logic c;
        logic n;
        logic z;
    } cc_t;

    localparam logic [1:0] CTR_RESET = 2'd1;
    localparam logic [1:0] CTR_MAX   = 2'd3;

    function automatic logic op_is_cond(xfer_op_e op);
        return (op == OP_JZ) || (op == OP_JN) || (op == OP_JC);
    endfunction

    function automatic logic op_is_uncond(xfer_op_e op);
        return op[2];
    endfunction

    // one-hot selector of the flag a conditional jump tests
    function automatic cc_t cond_sel(xfer_op_e op);
        cc_t s;
        s = '0;
        case (op)
            OP_JZ:   s.z = 1'b1;
            OP_JN:   s.n = 1'b1;
            OP_JC:   s.c = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

    function automatic logic [1:0] ctr_step(logic [1:0] cur, logic up);
        if (up)
            return (cur == CTR_MAX) ? cur : cur + 2'd1;
        return (cur == 2'd0) ? cur : cur - 2'd1;
    endfunction

endpackage

// File: rtl/br_decide.sv
module br_decide
    import br_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            valid,
    input  xfer_op_e        op,
    input  cc_t             flags,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    output logic            taken,
    output logic            is_cond,
    output logic            is_uncond,
    output logic [PC_W-1:0] next_pc,
    output cc_t             clr
);
    cc_t sel;

    always_comb begin
        sel       = cond_sel(op);
        is_cond   = valid && op_is_cond(op);
        is_uncond = valid && op_is_uncond(op);
        taken     = is_uncond || (is_cond && ((sel & flags) != '0));
        clr       = (is_cond && taken) ? sel : '0;
        next_pc   = taken ? target : pc + PC_W'(1);
    end
endmodule

// File: rtl/br_ctr_table.sv
module br_ctr_table
    import br_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_pred,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [1:0] ctr [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                ctr[e] <= CTR_RESET;
            else if (upd_en && (upd_idx == IDX_W'(e)))
                ctr[e] <= ctr_step(ctr[e], upd_taken);
        end
    end

    assign rd_pred = ctr[rd_idx][1];
endmodule

// File: rtl/br_flush_gen.sv
module br_flush_gen #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            is_cond,
    input  logic            is_uncond,
    input  logic            taken,
    input  logic            pred,
    input  logic [PC_W-1:0] next_pc,
    output logic            flush,
    output logic [PC_W-1:0] flush_pc
);
    logic redirect;

    assign redirect = is_uncond || (is_cond && (taken != pred));

    always_ff @(posedge clk) begin
        if (rst) begin
            flush    <= 1'b0;
            flush_pc <= '0;
        end else begin
            flush    <= redirect;
            flush_pc <= redirect ? next_pc : flush_pc;
        end
    end
endmodule

// File: rtl/br_resolver.sv
module br_resolver
    import br_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            fetch_pred_taken,
    input  logic            rs_valid,
    input  logic [2:0]      rs_op,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_pred,
    input  logic [PC_W-1:0] rs_target,
    input  logic [2:0]      rs_flags,
    output logic            rs_taken,
    output logic [PC_W-1:0] rs_next_pc,
    output logic [2:0]      flag_clr,
    output logic            flush,
    output logic [PC_W-1:0] flush_pc
);
    logic is_cond;
    logic is_uncond;
    cc_t  clr_s;

    br_decide #(.PC_W(PC_W)) u_decide (
        .valid     (rs_valid),
        .op        (xfer_op_e'(rs_op)),
        .flags     (cc_t'(rs_flags)),
        .pc        (rs_pc),
        .target    (rs_target),
        .taken     (rs_taken),
        .is_cond   (is_cond),
        .is_uncond (is_uncond),
        .next_pc   (rs_next_pc),
        .clr       (clr_s)
    );

    assign flag_clr = clr_s;

    br_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (fetch_pc[IDX_W-1:0]),
        .rd_pred   (fetch_pred_taken),
        .upd_en    (is_cond),
        .upd_idx   (rs_pc[IDX_W-1:0]),
        .upd_taken (rs_taken)
    );

    br_flush_gen #(.PC_W(PC_W)) u_flush (
        .clk       (clk),
        .rst       (rst),
        .is_cond   (is_cond),
        .is_uncond (is_uncond),
        .taken     (rs_taken),
        .pred      (rs_pred),
        .next_pc   (rs_next_pc),
        .flush     (flush),
        .flush_pc  (flush_pc)
    );
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            rs_valid,
    input logic [2:0]      rs_op,
    input logic [PC_W-1:0] rs_pc,
    input logic [PC_W-1:0] rs_target,
    input logic [2:0]      rs_flags,
    input logic            rs_taken,
    input logic [PC_W-1:0] rs_next_pc,
    input logic [2:0]      flag_clr,
    input logic            flush,
    input logic [PC_W-1:0] flush_pc
);
    assert_clr_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_clr));

    assert_clr_only_set_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_clr & ~rs_flags) == 3'd0);

    assert_clr_implies_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_clr != 3'd0) |-> rs_taken);

    assert_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
        !rs_taken |-> (rs_next_pc == rs_pc + PC_W'(1)));

    assert_taken_target_R4: assert property (@(posedge clk) disable iff (rst)
        rs_taken |-> (rs_next_pc == rs_target));

    assert_uncond_flush_R5: assert property (@(posedge clk) disable iff (rst)
        (rs_valid && rs_op[2]) |=> flush);

    assert_flush_cause_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(rs_valid));

    assert_flush_pc_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> (flush_pc == $past(rs_next_pc)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!rs_valid || rs_op == 3'd0) |-> (!rs_taken && flag_clr == 3'd0));
endmodule

bind br_resolver br_resolver_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rs_valid   (rs_valid),
    .rs_op      (rs_op),
    .rs_pc      (rs_pc),
    .rs_target  (rs_target),
    .rs_flags   (rs_flags),
    .rs_taken   (rs_taken),
    .rs_next_pc (rs_next_pc),
    .flag_clr   (flag_clr),
    .flush      (flush),
    .flush_pc   (flush_pc)
);

// File: tb/test_br_resolver.sv
module test_br_resolver;
    localparam int PC_W  = 32;
    localparam int IDX_W = 4;
    localparam int NENT  = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            fetch_pred_taken;
    logic            rs_valid = 1'b0;
    logic [2:0]      rs_op = '0;
    logic [PC_W-1:0] rs_pc = '0;
    logic            rs_pred = 1'b0;
    logic [PC_W-1:0] rs_target = '0;
    logic [2:0]      rs_flags = '0;
    logic            rs_taken;
    logic [PC_W-1:0] rs_next_pc;
    logic [2:0]      flag_clr;
    logic            flush;
    logic [PC_W-1:0] flush_pc;

    int n_vec  = 0;
    int n_miss = 0;
    int mdl [NENT];
    bit done = 0;

    always #10 clk = ~clk;

    br_resolver #(.PC_W(PC_W), .IDX_W(IDX_W)) i_br_resolver (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_pred_taken(fetch_pred_taken),
        .rs_valid(rs_valid), .rs_op(rs_op), .rs_pc(rs_pc), .rs_pred(rs_pred),
        .rs_target(rs_target), .rs_flags(rs_flags), .rs_taken(rs_taken),
        .rs_next_pc(rs_next_pc), .flag_clr(flag_clr), .flush(flush), .flush_pc(flush_pc)
    );

    task automatic check(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one resolve cycle followed by one idle cycle
    task automatic resolve(bit v, int op, int f, bit pred, logic [PC_W-1:0] pc,
                           logic [PC_W-1:0] tgt);
        bit cond, unc, tk, fl;
        logic [2:0] clr;
        logic [PC_W-1:0] npc;
        int idx;
        cond = v && (op >= 1 && op <= 3);
        unc  = v && (op >= 4);
        tk   = unc || (cond && f[op-1]);
        clr  = (cond && tk) ? 3'(1 << (op - 1)) : 3'd0;
        npc  = tk ? tgt : pc + 1;
        fl   = unc || (cond && (tk != pred));
        idx  = int'(pc[IDX_W-1:0]);

        @(negedge clk);
        rs_valid = v; rs_op = 3'(op); rs_flags = 3'(f); rs_pred = pred;
        rs_pc = pc; rs_target = tgt; fetch_pc = pc;
        #2;
        check(cond ? "R2" : (unc ? "R5" : "R9"), "taken", PC_W'(rs_taken), PC_W'(tk));
        check("R3", "flag_clr", PC_W'(flag_clr), PC_W'(clr));
        check("R4", "next_pc", rs_next_pc, npc);
        @(posedge clk);
        if (cond) begin
            if (tk) mdl[idx] = (mdl[idx] == 3) ? 3 : mdl[idx] + 1;
            else    mdl[idx] = (mdl[idx] == 0) ? 0 : mdl[idx] - 1;
        end
        #2;
        check(unc ? "R5" : "R8", "flush", PC_W'(flush), PC_W'(fl));
        if (fl) check("R8", "flush_pc", flush_pc, npc);
        check(cond ? "R6" : "R7", "pred", PC_W'(fetch_pred_taken), PC_W'(mdl[idx] >= 2));
        @(negedge clk);
        rs_valid = 1'b0; rs_op = '0;
        @(posedge clk); #2;
        check("R8", "flush one cycle", PC_W'(flush), '0);
    endtask

    initial begin
        for (int i = 0; i < NENT; i++) mdl[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        check("R1", "flush after reset", PC_W'(flush), '0);
        for (int i = 0; i < NENT; i++) begin
            fetch_pc = PC_W'(32'h0BAD_0000 + (i << 8) + i);
            #1;
            check("R1", "reset pred", PC_W'(fetch_pred_taken), '0);
        end

        // full cross: opcode x flags x prediction, spread over indices
        for (int op = 0; op < 8; op++)
            for (int f = 0; f < 8; f++)
                for (int p = 0; p < 2; p++) begin
                    int k = op * 16 + f * 2 + p;
                    resolve(1'b1, op, f, p[0], PC_W'(32'h0040_0000 + k * 37),
                            PC_W'(32'hA500_0000 ^ (k * 32'h0001_0111)));
                end

        // invalid cycles carrying live-looking branches
        for (int op = 1; op < 8; op++)
            resolve(1'b0, op, 7, 1'b0, PC_W'(32'h0000_0100 + op), 32'hDEAD_BEEF);

        // saturation walk on every index: up past 3, down past 0
        for (int i = 0; i < NENT; i++) begin
            for (int s = 0; s < 4; s++)
                resolve(1'b1, 1 + (i % 3), 7, (mdl[i] >= 2),
                        PC_W'(32'h0800_0000 + (s << 12) + i), PC_W'(32'h0000_4000 + i));
            for (int s = 0; s < 5; s++)
                resolve(1'b1, 1 + (i % 3), 0, (mdl[i] >= 2),
                        PC_W'(32'h0900_0000 + (s << 12) + i), PC_W'(32'h0000_5000 + i));
            // unconditional at the same index leaves counter at 0
            resolve(1'b1, 4 + (i % 4), 0, 1'b1, PC_W'(32'h0A00_0000 + i), 32'h0000_6000);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule